// File: doc/BRIEF.md
# Memory Fence Ordering Unit

This block sits beside the issue stage of a processor whose data memory operations may finish in any order. It keeps a count of data operations that have been issued and have not yet finished, and it uses that count to put fences into effect. A full fence stops younger operations from issuing until every older operation has finished. An acquire fence stops younger operations until the synchronising access itself is acknowledged, and it does not wait for older traffic. A release fence lets younger operations keep issuing, and it completes only once every older operation has drained.

Release needs to tell older operations apart from younger ones while both are in flight. Each issued operation is therefore stamped with a one-bit epoch tag. The completion path hands this tag back, and the unit keeps one counter per epoch. Accepting a release flips the current epoch, so the counter for the previous epoch holds only traffic that is older than the release. Only one fence is handled at a time, which keeps fences in program order: the processor holds its next fence until `fence_ready` comes back.

The sequencer has four states. `ST_IDLE` accepts a fence. `ST_DRAIN_ALL` is the full fence. `ST_HOLD_ACQ` is the acquire. `ST_DRAIN_OLD` is the release. The transitions are as follows:
- `ST_IDLE` goes to one of the other three states, chosen by the fence kind, when a fence request arrives.
- `ST_DRAIN_ALL` returns to `ST_IDLE` once both counters read zero.
- `ST_HOLD_ACQ` returns to `ST_IDLE` when `sync_ack` is high.
- `ST_DRAIN_OLD` returns to `ST_IDLE` once the previous epoch's counter reads zero.

Every return to `ST_IDLE` comes with a one-cycle `fence_done`.

Top module: `fence_order_unit`

## Requirements
- R1: An `op_issue` pulse while `issue_en` is high adds one to the counter of the current epoch (`issue_tag`). An `op_cpl` pulse takes one from the counter selected by `cpl_tag`. `outstanding`, the sum of both counters, shows the new value in the next cycle.
- R2: An issue and a completion in the same cycle against the same epoch leave that counter unchanged.
- R3: A full fence is requested with `fence_kind` = 2'b00 (2'b11 is also treated as full). It raises `fence_done` in the first cycle after acceptance in which both counters read zero. With nothing outstanding, that is the cycle right after the request.
- R4: While a full fence is pending, `issue_en` is low. An `op_issue` pulse in that time is ignored and does not change `outstanding`.
- R5: `fence_ready` is high only when no fence is pending. A `fence_req` while `fence_ready` is low is ignored, so fences complete one at a time in program order.
- R6: An acquire fence is requested with `fence_kind` = 2'b01. It holds `issue_en` low from the cycle after the request until the cycle in which `sync_ack` is high, and it raises `fence_done` in that same cycle whatever the count.
- R7: A release fence is requested with `fence_kind` = 2'b10. It keeps `issue_en` high and flips `issue_tag` from the next cycle on. It raises `fence_done` in the first cycle in which the counter for the previous epoch reads zero, even if younger operations are still outstanding.
- R8: A completion against an epoch counter that reads zero leaves that counter at zero. It also sets `err_underflow` from the next cycle on, and the flag then stays high until reset.
- R9: An issue against an epoch counter at its maximum (2^CNT_W-1) leaves that counter at its maximum.
- R10: After reset, `issue_en` and `fence_ready` are high, `fence_done` and `err_underflow` are low, and `outstanding` and `issue_tag` are zero.
- R11: `fence_done` lasts one cycle, and `fence_ready` is high in the cycle that follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_issue | input | 1 | A data operation issues this cycle (counted only when issue_en is high) |
| issue_en | output | 1 | Younger data operations may issue |
| issue_tag | output | 1 | Epoch tag to attach to the operation issued this cycle |
| op_cpl | input | 1 | A data operation completes this cycle |
| cpl_tag | input | 1 | Epoch tag carried by the completing operation |
| fence_req | input | 1 | Fence request, taken only when fence_ready is high |
| fence_kind | input | 2 | 00 full, 01 acquire, 10 release, 11 full |
| sync_ack | input | 1 | The acquire access itself has completed |
| fence_ready | output | 1 | No fence pending; a new fence may be presented |
| fence_done | output | 1 | One-cycle pulse when the pending fence retires |
| err_underflow | output | 1 | Sticky flag: a completion arrived with its epoch counter at zero |
| outstanding | output | CNT_W+1 | Sum of both epoch counters |

## Verification
The bench builds the unit with CNT_W = 3, so each epoch counter tops out at 7. The saturation boundary of R9 is then reachable with nine back-to-back issues. Because the count stays small, every full, acquire and release scenario can have its exact retirement cycle worked out by hand. Those cycles go into a scoreboard queue, and each observed `fence_done` pulse is matched against them. The release scenario keeps one younger operation in flight across the retirement, which separates the per-epoch drain from a drain of the total count.

// File: rtl/fence_ord_pkg.sv
package fence_ord_pkg;

    typedef enum logic [1:0] {
        KIND_FULL = 2'b00,
        KIND_ACQ  = 2'b01,
        KIND_REL  = 2'b10,
        KIND_RSVD = 2'b11
    } fence_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DRAIN_ALL,
        ST_HOLD_ACQ,
        ST_DRAIN_OLD
    } seq_state_e;

    localparam int NUM_EPOCH = 2;

endpackage

// File: rtl/fence_op_counter.sv
module fence_op_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             underflow
);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        unique case ({inc, dec})
            2'b10: if (cnt_q != CNT_MAX)  cnt_d = cnt_q + 1'b1;
            2'b01: if (cnt_q != CNT_ZERO) cnt_d = cnt_q - 1'b1;
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= CNT_ZERO;
        else        cnt_q <= cnt_d;
    end

    assign cnt       = cnt_q;
    assign underflow = dec && !inc && (cnt_q == CNT_ZERO);

    // R2: issue and completion together leave the count where it was
    a_r2_pair_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec) |=> (cnt == $past(cnt)));

    // R8: completion against an empty counter keeps it at zero
    a_r8_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && cnt == CNT_ZERO) |=> (cnt == CNT_ZERO));

    // R9: issue against a full counter keeps it at the ceiling
    a_r9_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

endmodule

// File: rtl/fence_seq_fsm.sv
module fence_seq_fsm
    import fence_ord_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fence_req,
    input  logic [1:0] fence_kind,
    input  logic       sync_ack,
    input  logic       all_zero,
    input  logic       old_zero,
    output logic       issue_en,
    output logic       fence_ready,
    output logic       fence_done,
    output logic       rel_accept
);
    seq_state_e  state_q;
    seq_state_e  state_d;
    fence_kind_e kind;

    assign kind = fence_kind_e'(fence_kind);

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fence_req) begin
                    unique case (kind)
                        KIND_ACQ:  state_d = ST_HOLD_ACQ;
                        KIND_REL:  state_d = ST_DRAIN_OLD;
                        KIND_FULL,
                        KIND_RSVD: state_d = ST_DRAIN_ALL;
                    endcase
                end
            end
            ST_DRAIN_ALL: if (all_zero) state_d = ST_IDLE;
            ST_HOLD_ACQ:  if (sync_ack) state_d = ST_IDLE;
            ST_DRAIN_OLD: if (old_zero) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        issue_en    = 1'b1;
        fence_ready = 1'b0;
        fence_done  = 1'b0;
        rel_accept  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                fence_ready = 1'b1;
                rel_accept  = fence_req && (kind == KIND_REL);
            end
            ST_DRAIN_ALL: begin
                issue_en   = 1'b0;
                fence_done = all_zero;
            end
            ST_HOLD_ACQ: begin
                issue_en   = 1'b0;
                fence_done = sync_ack;
            end
            ST_DRAIN_OLD: begin
                fence_done = old_zero;
            end
        endcase
    end

    // R11: the retirement pulse is a single cycle
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fence_done |=> !fence_done);

    // R11/R5: after retiring, a new fence may be presented
    a_r11_ready_after: assert property (@(posedge clk) disable iff (!rst_n)
        fence_done |=> fence_ready);

    // R5: a request while busy does not change the pending fence
    a_r5_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fence_ready && !fence_done) |=> !fence_ready);

endmodule

// File: rtl/fence_order_unit.sv
module fence_order_unit
    import fence_ord_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_issue,
    output logic             issue_en,
    output logic             issue_tag,
    input  logic             op_cpl,
    input  logic             cpl_tag,
    input  logic             fence_req,
    input  logic [1:0]       fence_kind,
    input  logic             sync_ack,
    output logic             fence_ready,
    output logic             fence_done,
    output logic             err_underflow,
    output logic [CNT_W:0]   outstanding
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    logic                 epoch_q;
    logic                 rel_accept;
    logic                 all_zero;
    logic                 old_zero;
    logic                 err_q;
    logic [NUM_EPOCH-1:0] inc_v;
    logic [NUM_EPOCH-1:0] dec_v;
    logic [NUM_EPOCH-1:0] uf_v;
    logic [CNT_W-1:0]     cnt_v [NUM_EPOCH];

    always_comb begin
        for (int e = 0; e < NUM_EPOCH; e++) begin
            inc_v[e] = op_issue && issue_en && (epoch_q == e[0]);
            dec_v[e] = op_cpl && (cpl_tag == e[0]);
        end
    end

    for (genvar g = 0; g < NUM_EPOCH; g++) begin : g_epoch
        fence_op_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .inc       (inc_v[g]),
            .dec       (dec_v[g]),
            .cnt       (cnt_v[g]),
            .underflow (uf_v[g])
        );
    end

    assign all_zero = (cnt_v[0] == CNT_ZERO) && (cnt_v[1] == CNT_ZERO);
    assign old_zero = (cnt_v[~epoch_q] == CNT_ZERO);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epoch_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (rel_accept) epoch_q <= ~epoch_q;
            if (|uf_v)      err_q   <= 1'b1;
        end
    end

    fence_seq_fsm u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .fence_req   (fence_req),
        .fence_kind  (fence_kind),
        .sync_ack    (sync_ack),
        .all_zero    (all_zero),
        .old_zero    (old_zero),
        .issue_en    (issue_en),
        .fence_ready (fence_ready),
        .fence_done  (fence_done),
        .rel_accept  (rel_accept)
    );

    assign issue_tag     = epoch_q;
    assign err_underflow = err_q;
    assign outstanding   = {1'b0, cnt_v[0]} + {1'b0, cnt_v[1]};

    // R4: a blocked issue with no completion leaves the count alone
    a_r4_blocked_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (op_issue && !issue_en && !op_cpl) |=> (outstanding == $past(outstanding)));

    // R8: the underflow flag is sticky
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow |=> err_underflow);

    // R7: the epoch tag flips only when a release is taken
    a_r7_tag_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (!fence_ready || !fence_req) |=> $stable(issue_tag));

    // R3: a full fence cannot retire with anything outstanding
    a_r3_full_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_done && !issue_en && !sync_ack) |-> (outstanding == '0));

endmodule

// File: tb/test_fence_order_unit.sv
module test_fence_order_unit;
    localparam int CNT_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             op_issue = 1'b0;
    logic             op_cpl = 1'b0;
    logic             cpl_tag = 1'b0;
    logic             fence_req = 1'b0;
    logic [1:0]       fence_kind = 2'b00;
    logic             sync_ack = 1'b0;
    logic             issue_en;
    logic             issue_tag;
    logic             fence_ready;
    logic             fence_done;
    logic             err_underflow;
    logic [CNT_W:0]   outstanding;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;
    int exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fence_order_unit #(.CNT_W(CNT_W)) i_fence_order_unit (
        .clk(clk), .rst_n(rst_n), .op_issue(op_issue), .issue_en(issue_en),
        .issue_tag(issue_tag), .op_cpl(op_cpl), .cpl_tag(cpl_tag),
        .fence_req(fence_req), .fence_kind(fence_kind), .sync_ack(sync_ack),
        .fence_ready(fence_ready), .fence_done(fence_done),
        .err_underflow(err_underflow), .outstanding(outstanding)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // drive one cycle of inputs, starting at a falling edge
    task automatic go(input bit iss, input bit cpl, input bit ctag,
                      input bit freq, input logic [1:0] kind, input bit ack);
        @(negedge clk);
        op_issue   = iss;
        op_cpl     = cpl;
        cpl_tag    = ctag;
        fence_req  = freq;
        fence_kind = kind;
        sync_ack   = ack;
    endtask

    task automatic idle();
        go(0, 0, 0, 0, 2'b00, 0);
    endtask

    // scoreboard driver side: expected retirement cycle
    task automatic expect_done(input int at);
        exp_q.push_back(at);
    endtask

    // scoreboard monitor side
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (mon_on && fence_done) begin
                if (exp_q.size() == 0) begin
                    check("R3/R6/R7 unexpected fence_done", 1, 0);
                end else begin
                    int want;
                    want = exp_q.pop_front();
                    check("R3/R6/R7 fence_done cycle", cyc, want);
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle();
        #1;
        // R10 reset state
        check("R10 issue_en", int'(issue_en), 1);
        check("R10 fence_ready", int'(fence_ready), 1);
        check("R10 fence_done", int'(fence_done), 0);
        check("R10 err_underflow", int'(err_underflow), 0);
        check("R10 outstanding", int'(outstanding), 0);
        check("R10 issue_tag", int'(issue_tag), 0);
        mon_on = 1'b1;

        // R1 counting
        for (int i = 0; i < 3; i++) go(1, 0, 0, 0, 2'b00, 0);
        idle(); #1;
        check("R1 three issues", int'(outstanding), 3);
        go(0, 1, 0, 0, 2'b00, 0);
        idle(); #1;
        check("R1 one completion", int'(outstanding), 2);
        go(1, 0, 0, 0, 2'b00, 0);

        // R2 simultaneous issue and completion
        go(1, 1, 0, 0, 2'b00, 0);
        idle(); #1;
        check("R2 paired cycle", int'(outstanding), 3);

        // R3/R4 full fence with three outstanding
        go(0, 0, 0, 1, 2'b00, 0);
        idle(); #1;
        check("R4 issue_en low in full fence", int'(issue_en), 0);
        check("R5 fence_ready low while pending", int'(fence_ready), 0);
        go(1, 0, 0, 0, 2'b00, 0);
        go(0, 1, 0, 0, 2'b00, 0);
        go(0, 1, 0, 0, 2'b00, 0);
        go(0, 1, 0, 0, 2'b00, 0);
        expect_done(cyc + 1);
        idle(); #1;
        check("R4 blocked issue not counted", int'(outstanding), 0);
        idle(); #1;
        check("R3 issue_en back after full fence", int'(issue_en), 1);
        check("R11 fence_ready after done", int'(fence_ready), 1);

        // R3 full fence with nothing outstanding (reserved kind 11)
        go(0, 0, 0, 1, 2'b11, 0);
        expect_done(cyc + 1);
        idle();
        idle(); #1;
        check("R3 empty fence retired", int'(issue_en), 1);

        // R6 acquire does not wait for older operations
        go(1, 0, 0, 0, 2'b00, 0);
        go(1, 0, 0, 0, 2'b00, 0);
        go(0, 0, 0, 1, 2'b01, 0);
        idle(); #1;
        check("R6 issue_en low during acquire", int'(issue_en), 0);
        idle(); #1;
        check("R6 still held without ack", int'(fence_ready), 0);
        check("R6 older still outstanding", int'(outstanding), 2);
        go(0, 0, 0, 0, 2'b00, 1);
        expect_done(cyc);
        idle(); #1;
        check("R6 issue_en after ack", int'(issue_en), 1);
        go(0, 1, 0, 0, 2'b00, 0);
        go(0, 1, 0, 0, 2'b00, 0);
        idle(); #1;
        check("R6 drained", int'(outstanding), 0);

        // R7 release waits only for older epoch
        go(1, 0, 0, 0, 2'b00, 0);
        go(1, 0, 0, 0, 2'b00, 0);
        go(0, 0, 0, 1, 2'b10, 0);
        go(1, 0, 0, 0, 2'b00, 0); #1;
        check("R7 issue_en high in release", int'(issue_en), 1);
        check("R7 tag flipped", int'(issue_tag), 1);
        check("R5 not ready in release", int'(fence_ready), 0);
        go(0, 1, 0, 0, 2'b00, 0);
        go(0, 1, 0, 0, 2'b00, 0);
        expect_done(cyc + 1);
        idle(); #1;
        check("R7 younger still outstanding", int'(outstanding), 1);
        go(0, 1, 1, 0, 2'b00, 0);
        idle(); #1;
        check("R7 younger drained", int'(outstanding), 0);

        // R8 underflow
        check("R8 flag clear before", int'(err_underflow), 0);
        go(0, 1, 0, 0, 2'b00, 0);
        idle(); #1;
        check("R8 flag raised", int'(err_underflow), 1);
        check("R8 counter floor", int'(outstanding), 0);
        idle(); #1;
        check("R8 flag sticky", int'(err_underflow), 1);

        // R9 saturation (epoch 1 counter)
        for (int i = 0; i < 9; i++) go(1, 0, 0, 0, 2'b00, 0);
        idle(); #1;
        check("R9 ceiling", int'(outstanding), 7);
        for (int i = 0; i < 7; i++) go(0, 1, 1, 0, 2'b00, 0);
        idle(); #1;
        check("R9 drained", int'(outstanding), 0);

        // R5 second fence while busy is ignored
        go(1, 0, 0, 0, 2'b00, 0);
        go(0, 0, 0, 1, 2'b00, 0);
        go(0, 0, 0, 1, 2'b01, 0);
        go(0, 1, 1, 0, 2'b00, 0);
        expect_done(cyc + 1);
        idle();
        idle(); #1;
        check("R5 ignored acquire left no hold", int'(issue_en), 1);
        check("R5 ready again", int'(fence_ready), 1);

        repeat (3) idle();
        check("R11 scoreboard empty", exp_q.size(), 0);
        finish_run();
    end
endmodule